// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept or discarded, judging only by its 48-bit destination address and its length. Two programmable unicast addresses can each be enabled for an exact comparison. The all-ones broadcast address can be admitted on request. A 64-entry group table catches multicast traffic. The table is indexed by a 6-bit fold of the address: the address is cut into eight 6-bit slices and the slices are XORed together.

A frame is offered by presenting its destination address, with byte 0 (the first byte on the wire) in bits 7:0, together with its length and a one-cycle valid strobe. One clock later the block raises a single-cycle done pulse, and the accept output carries the decision during that pulse. Configuration is written through a small word-wide write port: a 3-bit select and 32-bit data. Every configuration register resets to zero, so the block discards all traffic until software programs it.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every configuration register is zero, done and accept are low, and any frame offered without further configuration is dropped, including broadcast.
- R2: done is high for exactly the one cycle after the cycle in which dst_valid is high. accept is low whenever done is low.
- R3: With control bit 0 set, a frame whose address equals exact address 0 is accepted. Exact address 0 is written as select 0 (bytes 0..3, byte 0 in bits 7:0) and select 1 (bytes 4 and 5 in bits 15:0). An address that differs in any byte does not match.
- R4: With control bit 1 set, a frame whose address equals exact address 1 is accepted. Exact address 1 is written as select 2 (low word) and select 3 (high word), in the same layout as exact address 0.
- R5: The all-ones address is accepted only when control bit 3 is set.
- R6: The hash is the XOR of the eight 6-bit slices of the address; slice k is bits 6k+5..6k of the address. A hash of 0..31 tests that bit of the table low word (select 4), and a hash of 32..63 tests bit (hash-32) of the table high word (select 5). A set bit accepts the frame.
- R7: The table is consulted only when address bit 0 (the multicast bit of byte 0) is set, unless control bit 2 is set, in which case non-multicast addresses are hashed as well.
- R8: A frame with a length below 12 bytes is dropped whatever its address.
- R9: An exact address whose enable bit is clear has no effect on the decision.
- R10: The control register is written with select 6. Only bits 3:0 of the data are kept. Select 7 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| dst_valid | input | 1 | Destination address and length are valid this cycle |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| frame_len | input | 16 | Frame length in bytes |
| done | output | 1 | Decision strobe, one cycle after dst_valid |
| accept | output | 1 | Frame kept (1) or dropped (0), valid with done |

## Verification
The filter is tried with matching and near-miss unicast addresses against each exact slot, with each slot's enable set and cleared. It is also tried with the broadcast address with the broadcast enable on and off. Multicast addresses are chosen so that their hash lands in the low and in the high table word, which separates the word selection. A neighbouring table bit is set alone to show that the index is exact. A unicast address whose hash bit is set shows the effect of the individual-hashing option. Lengths of 11 and 12 bytes bracket the short-frame limit.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int MAC_W      = 48;
  localparam int HASH_W     = 6;
  localparam int SLICES     = MAC_W / HASH_W;
  localparam int TBL_WORD_W = 32;
  localparam int CTRL_W     = 4;

  // control bit positions
  localparam int CB_EX0   = 0;
  localparam int CB_EX1   = 1;
  localparam int CB_INDIV = 2;
  localparam int CB_BCAST = 3;

  // fold the address into a table index: XOR of consecutive 6-bit slices
  function automatic logic [HASH_W-1:0] fold_hash(input logic [MAC_W-1:0] a);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int i = 0; i < SLICES; i++) h ^= a[i*HASH_W +: HASH_W];
    return h;
  endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int NUM_EXACT = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [2:0]                       sel,
  input  logic [31:0]                      wdata,
  output logic [NUM_EXACT-1:0][MAC_W-1:0]  ex_addr,
  output logic [2*TBL_WORD_W-1:0]          table_bits,
  output logic [CTRL_W-1:0]                ctrl
);
  localparam int SEL_TBL_LO = 2 * NUM_EXACT;
  localparam int SEL_TBL_HI = 2 * NUM_EXACT + 1;
  localparam int SEL_CTRL   = 2 * NUM_EXACT + 2;

  logic [TBL_WORD_W-1:0] tbl_lo, tbl_hi;

  for (genvar g = 0; g < NUM_EXACT; g++) begin : g_slot
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (we) begin
        if (32'(sel) == 2*g)     lo_q <= wdata;
        if (32'(sel) == 2*g + 1) hi_q <= wdata[15:0];
      end
    end
    assign ex_addr[g] = {hi_q, lo_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_lo <= '0;
      tbl_hi <= '0;
      ctrl   <= '0;
    end else if (we) begin
      if (32'(sel) == SEL_TBL_LO) tbl_lo <= wdata[TBL_WORD_W-1:0];
      if (32'(sel) == SEL_TBL_HI) tbl_hi <= wdata[TBL_WORD_W-1:0];
      if (32'(sel) == SEL_CTRL)   ctrl   <= wdata[CTRL_W-1:0];
    end
  end

  assign table_bits = {tbl_hi, tbl_lo};

  a_r10_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && 32'(sel) == SEL_CTRL) |=> ctrl == $past(wdata[CTRL_W-1:0]));
  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we || 32'(sel) != SEL_CTRL) |=> $stable(ctrl));
endmodule

// File: rtl/rxf_exact_match.sv
module rxf_exact_match
  import rxf_pkg::*;
(
  input  logic             enable,
  input  logic [MAC_W-1:0] ref_addr,
  input  logic [MAC_W-1:0] dst,
  output logic             hit
);
  assign hit = enable && (ref_addr == dst);
endmodule

// File: rtl/rxf_hash_lookup.sv
module rxf_hash_lookup
  import rxf_pkg::*;
(
  input  logic [MAC_W-1:0]        dst,
  input  logic [2*TBL_WORD_W-1:0] table_bits,
  input  logic                    indiv_en,
  output logic [HASH_W-1:0]       hash_idx,
  output logic                    consult,
  output logic                    hit
);
  logic [TBL_WORD_W-1:0] lo_w, hi_w, word;
  logic [HASH_W-2:0]     bit_sel;

  assign hash_idx = fold_hash(dst);
  assign lo_w     = table_bits[TBL_WORD_W-1:0];
  assign hi_w     = table_bits[2*TBL_WORD_W-1:TBL_WORD_W];
  assign word     = hash_idx[HASH_W-1] ? hi_w : lo_w;
  assign bit_sel  = hash_idx[HASH_W-2:0];
  assign consult  = dst[0] || indiv_en;
  assign hit      = consult && word[bit_sel];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int NUM_EXACT = 2,
  parameter int LEN_W     = 16,
  parameter int MIN_LEN   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        dst_valid,
  input  logic [47:0] dst_addr,
  input  logic [LEN_W-1:0] frame_len,
  output logic        done,
  output logic        accept
);
  logic [NUM_EXACT-1:0][MAC_W-1:0] ex_addr;
  logic [2*TBL_WORD_W-1:0]         table_bits;
  logic [CTRL_W-1:0]               ctrl;
  logic [NUM_EXACT-1:0]            ex_hit;
  logic [HASH_W-1:0]               hash_idx;
  logic                            hash_consult, hash_hit, bcast_hit, short_frame, decision;

  rxf_cfg_regs #(.NUM_EXACT(NUM_EXACT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .ex_addr(ex_addr), .table_bits(table_bits), .ctrl(ctrl)
  );

  for (genvar g = 0; g < NUM_EXACT; g++) begin : g_ex
    rxf_exact_match u_cmp (
      .enable(ctrl[CB_EX0 + g]), .ref_addr(ex_addr[g]), .dst(dst_addr), .hit(ex_hit[g])
    );
  end

  rxf_hash_lookup u_hash (
    .dst(dst_addr), .table_bits(table_bits), .indiv_en(ctrl[CB_INDIV]),
    .hash_idx(hash_idx), .consult(hash_consult), .hit(hash_hit)
  );

  assign bcast_hit   = ctrl[CB_BCAST] && (&dst_addr);
  assign short_frame = frame_len < LEN_W'(MIN_LEN);
  assign decision    = !short_frame && ((|ex_hit) || bcast_hit || hash_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      accept <= 1'b0;
    end else begin
      done   <= dst_valid;
      accept <= dst_valid && decision;
    end
  end

  a_r2_done_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> done);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> !done);
  a_r2_accept_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> done);
  a_r8_short_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && short_frame) |=> !accept);
  a_r5_bcast_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !short_frame && ctrl[CB_BCAST] && (&dst_addr)) |=> accept);
  a_r7_unicast_unhashed: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_addr[0] && !ctrl[CB_INDIV] && !(|ex_hit) && !bcast_hit) |=> !accept);
  a_r6_hash_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !short_frame && hash_consult && table_bits[hash_idx]) |=> accept);
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        dst_valid = 0;
  logic [47:0] dst_addr = 0;
  logic [15:0] frame_len = 0;
  logic        done, accept;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rx_addr_filter uut (.*);

  // reference state
  logic [31:0] m_lo0, m_lo1, m_tl, m_th;
  logic [15:0] m_hi0, m_hi1;
  logic [3:0]  m_ctrl;
  logic        m_done, m_acc;

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [5:0] h;
    for (int j = 0; j < 6; j++) begin
      h[j] = 1'b0;
      for (int i = 0; i < 8; i++) h[j] = h[j] ^ a[6*i + j];
    end
    return h;
  endfunction

  function automatic bit ref_accept(input logic [47:0] a, input int len);
    bit ok, m0, m1;
    int h;
    if (len < 12) return 0;
    m0 = 1; m1 = 1;
    for (int k = 0; k < 6; k++) begin
      if (a[8*k +: 8] != (k < 4 ? m_lo0[8*k +: 8] : m_hi0[8*(k-4) +: 8])) m0 = 0;
      if (a[8*k +: 8] != (k < 4 ? m_lo1[8*k +: 8] : m_hi1[8*(k-4) +: 8])) m1 = 0;
    end
    ok = (m_ctrl[0] && m0) || (m_ctrl[1] && m1) || (m_ctrl[3] && a == 48'hFFFF_FFFF_FFFF);
    if (a[0] || m_ctrl[2]) begin
      h = int'(ref_hash(a));
      if (h > 31) ok = ok || m_th[h-32];
      else        ok = ok || m_tl[h];
    end
    return ok;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo0 <= 0; m_lo1 <= 0; m_hi0 <= 0; m_hi1 <= 0;
      m_tl <= 0; m_th <= 0; m_ctrl <= 0; m_done <= 0; m_acc <= 0;
    end else begin
      if (cfg_we) case (cfg_sel)
        3'd0: m_lo0 <= cfg_wdata;
        3'd1: m_hi0 <= cfg_wdata[15:0];
        3'd2: m_lo1 <= cfg_wdata;
        3'd3: m_hi1 <= cfg_wdata[15:0];
        3'd4: m_tl  <= cfg_wdata;
        3'd5: m_th  <= cfg_wdata;
        3'd6: m_ctrl <= cfg_wdata[3:0];
        default: ;
      endcase
      m_done <= dst_valid;
      m_acc  <= dst_valid && ref_accept(dst_addr, int'(frame_len));
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (done !== m_done || accept !== m_acc) begin
        errors++;
        $display("FAIL model R2 cycle: done/accept=%b%b expected %b%b", done, accept, m_done, m_acc);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input string tag, input logic [47:0] a, input int len, input logic exp);
    @(negedge clk);
    dst_valid = 1; dst_addr = a; frame_len = 16'(len);
    @(negedge clk);
    dst_valid = 0;
    chk({tag, " done"}, done, 1'b1);
    chk(tag, accept, exp);
    @(negedge clk);
    chk("R2 done single", done, 1'b0);
  endtask

  localparam logic [47:0] A0 = 48'h5544_3322_1102;
  localparam logic [47:0] A1 = 48'hFEDC_BA98_760A;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  initial begin
    logic [47:0] mc_lo, mc_hi, uc;
    int hl, hh, hu;
    repeat (3) @(negedge clk);
    chk("R1 reset done", done, 1'b0);
    chk("R1 reset accept", accept, 1'b0);
    rst_n = 1;
    send("R1 bcast after reset", BC, 64, 1'b0);
    send("R1 addr after reset", A0, 64, 1'b0);

    wr(0, 32'h3322_1102); wr(1, 32'hABCD_5544);
    send("R9 ex0 disabled", A0, 64, 1'b0);
    wr(6, 32'h1);
    send("R3 ex0 match", A0, 64, 1'b1);
    send("R3 ex0 byte5 miss", A0 ^ 48'h0100_0000_0000, 64, 1'b0);
    send("R3 ex0 byte0 miss", A0 ^ 48'h4, 64, 1'b0);

    wr(2, 32'hBA98_760A); wr(3, 32'h0000_FEDC);
    send("R9 ex1 disabled", A1, 64, 1'b0);
    wr(6, 32'h2);
    send("R4 ex1 match", A1, 64, 1'b1);
    send("R9 ex0 off", A0, 64, 1'b0);

    send("R5 bcast off", BC, 64, 1'b0);
    wr(6, 32'hFFFF_FFF8);
    send("R10 upper ctrl bits ignored", A0, 64, 1'b0);
    send("R5 bcast on", BC, 64, 1'b1);
    send("R8 short 11", BC, 11, 1'b0);
    send("R8 length 12", BC, 12, 1'b1);
    wr(7, 32'h0);
    send("R10 select 7 no write", BC, 64, 1'b1);

    // find multicast addresses hashing into each table word
    hl = -1; hh = -1;
    for (int k = 0; k < 256; k++) begin
      logic [47:0] c;
      int h;
      c = {8'(k), 40'h00_5E00_0001};
      h = int'(ref_hash(c));
      if (h < 32 && hl < 0) begin hl = h; mc_lo = c; end
      if (h >= 32 && hh < 0) begin hh = h; mc_hi = c; end
    end
    wr(6, 32'h0);
    send("R6 empty table", mc_lo, 64, 1'b0);
    wr(4, 32'h1 << hl);
    send("R6 low word hit", mc_lo, 64, 1'b1);
    send("R6 high word miss", mc_hi, 64, 1'b0);
    wr(4, 32'h0);
    wr(5, 32'h1 << ((hh - 32) ^ 1));
    send("R6 neighbour bit only", mc_hi, 64, 1'b0);
    wr(5, 32'h1 << (hh - 32));
    send("R6 high word hit", mc_hi, 64, 1'b1);
    send("R8 short hashed", mc_hi, 5, 1'b0);

    // unicast whose hash bit is set
    uc = mc_hi ^ 48'h41; // clears bit 0, preserves hash (bit0 and bit6 both flip)
    hu = int'(ref_hash(uc));
    chk("R6 bench hash equal", 1'(hu == hh), 1'b1);
    send("R7 unicast not hashed", uc, 64, 1'b0);
    wr(6, 32'h4);
    send("R7 individual hashing", uc, 64, 1'b1);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule